// File: doc/BRIEF.md
# Debug Scan Register Bank with Communications Mailbox

This block is a bank of debug registers that a host reaches through a 38-bit serial data-register chain. The TAP controller outside the block provides capture, shift and update strobes together with TDI, and the block returns TDO. One scan carries a 32-bit data field, a 5-bit register address and a direction bit. A write scan stores its data at the update strobe. A read scan only records the address at update. The addressed register's contents are then loaded into the chain at the capture of the next scan, so read data always arrives one scan late.

The bank holds a debug control register, whose bit 4 selects monitor-mode debug, and a set of watchpoint comparator registers for a parameterised number of units. It also provides a communications channel between host and core: one 32-bit mailbox in each direction, each with a full flag. A status register reports both flags and a fixed version number. When the host reads the core-to-host data register, the word is consumed. When the host reads the status register, nothing changes. For this reason a host ends a burst of data reads by sending the status address as a dummy.

Top module: `dbg_scan_regbank`

## Requirements
- R1: After reset, the debug control register, both mailbox flags, the pending read address (0) and the chain contents are all zero, so `tdo` is 0 and `monitor_mode` is 0.
- R2: A scan whose bit 37 is 1 writes bits 31:0 into the register addressed by bits 36:32 at the update strobe. A scan whose bit 37 is 0 records that address at update. The value of that register is returned in bits 31:0 of the following scan.
- R3: The chain is 38 bits long and shifts least-significant bit first. `tdo` is bit 0 of the chain. A capture loads zeros into bits 37:32.
- R4: A write scan to address 5 places the word on `core_rx_data` and sets `core_rx_full` in the next cycle. A `core_rx_take` pulse clears the flag, unless a host write to address 5 occurs in the same cycle, in which case the write wins.
- R5: A `core_tx_put` pulse stores `core_tx_data` and sets `core_tx_full`. A capture while the pending read address is 5 returns the stored word and clears `core_tx_full`. Scans repeated at address 5 therefore return successive words.
- R6: Address 4 reads as {VERSION[3:0] in bits 31:28, zeros, `core_tx_full` in bit 1, `core_rx_full` in bit 0}. Writes to address 4 are ignored, and reading it changes neither flag.
- R7: Address 0 holds DBG_CTRL_BITS (default 6) writable bits, and bits above them read as zero. `monitor_mode` follows bit 4 and changes only on a write to address 0.
- R8: Each watchpoint unit u has six 32-bit read/write registers at addresses 8+8u to 13+8u, so address 10 is unit 0's data value.
- R9: Writes to addresses not listed in R2 to R8 have no effect, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | Capture strobe: loads read data into the chain |
| shift_dr | input | 1 | Shift strobe: moves the chain one bit toward `tdo` |
| update_dr | input | 1 | Update strobe: performs the write or records the read address |
| tdi | input | 1 | Serial data in, enters at bit 37 |
| tdo | output | 1 | Serial data out, chain bit 0 |
| core_rx_take | input | 1 | Core has taken the host-to-core word |
| core_rx_data | output | 32 | Host-to-core word |
| core_rx_full | output | 1 | Host-to-core word pending |
| core_tx_put | input | 1 | Core writes a core-to-host word |
| core_tx_data | input | 32 | Core-to-host word to store |
| core_tx_full | output | 1 | Core-to-host word pending |
| monitor_mode | output | 1 | Debug control bit 4 |

## Verification
The bench writes a distinct arithmetic pattern to all 32 addresses, leaving out the two mailbox addresses. It then reads every address back in a pipelined chain. This separates stored registers, masked control bits, unmapped holes and status, and it shows that data returns one scan late. The mailbox is tested with separate sequences: repeated data-address reads that must pop one word each, status reads that must leave a pending word in place, and collisions between host writes and core takes on the flags. Patterns of all-ones and zero on the debug control register show the width mask and the monitor-mode bit.

// File: rtl/dbg_regbank_pkg.sv
`timescale 1ns/1ps
// Shared constants and the decoded layout of one scan word.
// Assumes a fixed 38-bit chain: direction bit, 5-bit address, 32-bit data.
package dbg_regbank_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int SCAN_W    = DATA_W + ADDR_W + 1;
    localparam int WP_BASE   = 8;
    localparam int WP_STRIDE = 8;
    localparam int WP_REGS   = 6;
    localparam int MON_BIT   = 4;

    localparam logic [ADDR_W-1:0] A_DBG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] A_DCC_STAT = 5'd4;
    localparam logic [ADDR_W-1:0] A_DCC_DATA = 5'd5;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_word_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
`timescale 1ns/1ps
// Serial chain: loads read data on capture, shifts LSB-first, presents the
// assembled word while update is high. Assumes strobes are mutually exclusive.
module dbg_scan_shifter
    import dbg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [DATA_W-1:0] cap_data,
    output logic              tdo,
    output scan_word_t        word
);
    logic [SCAN_W-1:0] shreg_q;

    // Chain register: capture loads, shift moves one bit toward tdo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (capture) begin
            shreg_q <= {{(SCAN_W-DATA_W){1'b0}}, cap_data};
        end else if (shift) begin
            shreg_q <= {tdi, shreg_q[SCAN_W-1:1]};
        end
    end

    assign tdo  = shreg_q[0];
    assign word = scan_word_t'(shreg_q);
endmodule

// File: rtl/dbg_wp_bank.sv
`timescale 1ns/1ps
// Storage for NUM_WP watchpoint comparator register sets, WP_REGS words each,
// placed at WP_BASE + unit*WP_STRIDE + index. Comparison is done elsewhere.
module dbg_wp_bank
    import dbg_regbank_pkg::*;
#(
    parameter int NUM_WP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREG = NUM_WP * WP_REGS;

    logic [DATA_W-1:0] wp_q [NREG];

    for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
        for (genvar r = 0; r < WP_REGS; r++) begin : g_reg
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(WP_BASE + u*WP_STRIDE + r);
            // One comparator register: loads on a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wp_q[u*WP_REGS+r] <= '0;
                end else if (wr_en && wr_addr == MY_ADDR) begin
                    wp_q[u*WP_REGS+r] <= wr_data;
                end
            end
        end
    end

    // Read decode across all units.
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int u = 0; u < NUM_WP; u++) begin
            for (int r = 0; r < WP_REGS; r++) begin
                if (rd_addr == ADDR_W'(WP_BASE + u*WP_STRIDE + r)) begin
                    rd_hit  = 1'b1;
                    rd_data = wp_q[u*WP_REGS+r];
                end
            end
        end
    end
endmodule

// File: rtl/dbg_dcc_mailbox.sv
`timescale 1ns/1ps
// Two single-word mailboxes with full flags. A set in the same cycle as a
// clear wins, so a new word is never lost.
module dbg_dcc_mailbox
    import dbg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    input  logic              core_take,
    input  logic              core_put,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_full,
    output logic [DATA_W-1:0] c2h_data,
    output logic              c2h_full
);
    // Host-to-core word and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2c_data <= '0;
            h2c_full <= 1'b0;
        end else if (host_wr) begin
            h2c_data <= host_wdata;
            h2c_full <= 1'b1;
        end else if (core_take) begin
            h2c_full <= 1'b0;
        end
    end

    // Core-to-host word and its flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2h_data <= '0;
            c2h_full <= 1'b0;
        end else if (core_put) begin
            c2h_data <= core_wdata;
            c2h_full <= 1'b1;
        end else if (host_pop) begin
            c2h_full <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_scan_regbank.sv
`timescale 1ns/1ps
// Debug register bank behind a 38-bit scan chain. Reads are pipelined by one
// scan. A capture that reads the data address pops the core-to-host word.
// Assumes capture/shift/update come from an external TAP, one at a time.
module dbg_scan_regbank
    import dbg_regbank_pkg::*;
#(
    parameter int         NUM_WP        = 2,
    parameter int         DBG_CTRL_BITS = 6,
    parameter logic [3:0] VERSION       = 4'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic        tdi,
    output logic        tdo,
    input  logic        core_rx_take,
    output logic [31:0] core_rx_data,
    output logic        core_rx_full,
    input  logic        core_tx_put,
    input  logic [31:0] core_tx_data,
    output logic        core_tx_full
    ,
    output logic        monitor_mode
);
    scan_word_t                 word;
    logic                       upd_write;
    logic [ADDR_W-1:0]          upd_addr;
    logic [DATA_W-1:0]          upd_data;
    logic                       wr_en;
    logic [ADDR_W-1:0]          rd_addr_q;
    logic [DBG_CTRL_BITS-1:0]   dbg_ctrl_q;
    logic [DATA_W-1:0]          cap_data;
    logic                       wp_hit;
    logic [DATA_W-1:0]          wp_data;
    logic [DATA_W-1:0]          c2h_data;
    logic                       host_pop;

    assign upd_write = word.write;
    assign upd_addr  = word.addr;
    assign upd_data  = word.data;
    assign wr_en     = update_dr && upd_write;
    assign host_pop  = capture_dr && (rd_addr_q == A_DCC_DATA);

    dbg_scan_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .tdi      (tdi),
        .cap_data (cap_data),
        .tdo      (tdo),
        .word     (word)
    );

    dbg_wp_bank #(.NUM_WP(NUM_WP)) u_wp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (upd_addr),
        .wr_data (upd_data),
        .rd_addr (rd_addr_q),
        .rd_hit  (wp_hit),
        .rd_data (wp_data)
    );

    dbg_dcc_mailbox u_dcc (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (wr_en && upd_addr == A_DCC_DATA),
        .host_wdata (upd_data),
        .host_pop   (host_pop),
        .core_take  (core_rx_take),
        .core_put   (core_tx_put),
        .core_wdata (core_tx_data),
        .h2c_data   (core_rx_data),
        .h2c_full   (core_rx_full),
        .c2h_data   (c2h_data),
        .c2h_full   (core_tx_full)
    );

    // Pending read address, recorded by read scans at update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= A_DBG_CTRL;
        end else if (update_dr && !upd_write) begin
            rd_addr_q <= upd_addr;
        end
    end

    // Debug control register, only its low DBG_CTRL_BITS are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_ctrl_q <= '0;
        end else if (wr_en && upd_addr == A_DBG_CTRL) begin
            dbg_ctrl_q <= upd_data[DBG_CTRL_BITS-1:0];
        end
    end

    // Read multiplexer feeding the next capture.
    always_comb begin
        cap_data = '0;
        if (rd_addr_q == A_DBG_CTRL) begin
            cap_data = DATA_W'(dbg_ctrl_q);
        end else if (rd_addr_q == A_DCC_STAT) begin
            cap_data = {VERSION, 26'd0, core_tx_full, core_rx_full};
        end else if (rd_addr_q == A_DCC_DATA) begin
            cap_data = c2h_data;
        end else if (wp_hit) begin
            cap_data = wp_data;
        end
    end

    assign monitor_mode = dbg_ctrl_q[MON_BIT];
endmodule

// File: rtl/dbg_scan_regbank_chk.sv
`timescale 1ns/1ps
// Protocol checker for the register bank's mailbox flags and control bit.
module dbg_scan_regbank_chk
    import dbg_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              capture_dr,
    input logic              update_dr,
    input logic              upd_write,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [DATA_W-1:0] upd_data,
    input logic [ADDR_W-1:0] rd_addr_q,
    input logic              core_rx_take,
    input logic [31:0]       core_rx_data,
    input logic              core_rx_full,
    input logic              core_tx_put,
    input logic              core_tx_full,
    input logic              monitor_mode
);
    logic host_dw;
    assign host_dw = update_dr && upd_write && upd_addr == A_DCC_DATA;

    a_r4_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        host_dw |=> core_rx_full && core_rx_data == $past(upd_data));

    a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_take && !host_dw |=> !core_rx_full);

    a_r5_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_put |=> core_tx_full);

    a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && rd_addr_q == A_DCC_DATA && !core_tx_put |=> !core_tx_full);

    a_r6_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && rd_addr_q == A_DCC_STAT && !core_tx_put |=> $stable(core_tx_full));

    a_r7_mon_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_dr && upd_write && upd_addr == A_DBG_CTRL) |=> $stable(monitor_mode));
endmodule

bind dbg_scan_regbank dbg_scan_regbank_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_dr   (capture_dr),
    .update_dr    (update_dr),
    .upd_write    (upd_write),
    .upd_addr     (upd_addr),
    .upd_data     (upd_data),
    .rd_addr_q    (rd_addr_q),
    .core_rx_take (core_rx_take),
    .core_rx_data (core_rx_data),
    .core_rx_full (core_rx_full),
    .core_tx_put  (core_tx_put),
    .core_tx_full (core_tx_full),
    .monitor_mode (monitor_mode)
);

// File: tb/dbg_scan_regbank_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: address sweep plus mailbox sequences.
module dbg_scan_regbank_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        core_rx_take = 0, core_tx_put = 0;
    logic [31:0] core_tx_data = '0;
    logic        tdo, core_rx_full, core_tx_full, monitor_mode;
    logic [31:0] core_rx_data;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;
    logic [5:0]  last_hi;

    dbg_scan_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .core_rx_take(core_rx_take), .core_rx_data(core_rx_data),
        .core_rx_full(core_rx_full), .core_tx_put(core_tx_put),
        .core_tx_data(core_tx_data), .core_tx_full(core_tx_full),
        .monitor_mode(monitor_mode)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input bit wr, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        logic [37:0] din, dout;
        din = {wr, a, d};
        @(negedge clk) capture_dr = 1;
        @(negedge clk) capture_dr = 0;
        for (int i = 0; i < 38; i++) begin
            shift_dr = 1; tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge clk) update_dr = 0;
        q = dout[31:0];
        last_hi = dout[37:32];
    endtask

    task automatic put(input logic [31:0] w);
        @(negedge clk) core_tx_put = 1; core_tx_data = w;
        @(negedge clk) core_tx_put = 0;
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'h9E37_79B9 * 32'(a + 1);
    endfunction

    function automatic bit is_wp(input int a);
        return (a >= 8 && a <= 13) || (a >= 16 && a <= 21);
    endfunction

    function automatic logic [31:0] exp_val(input int a);
        if (a == 0) return pat(0) & 32'h3F;
        if (a == 4) return 32'h2000_0000;
        if (is_wp(a)) return pat(a);
        return 32'h0;
    endfunction

    function automatic string tag(input int a);
        if (a == 0) return "R7";
        if (a == 4) return "R6";
        if (is_wp(a)) return "R8";
        return "R9";
    endfunction

    initial begin
        logic [31:0] q;
        int prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 tdo", 32'(tdo), 0);
        chk("R1 rx_full", 32'(core_rx_full), 0);
        chk("R1 tx_full", 32'(core_tx_full), 0);
        chk("R1 monitor", 32'(monitor_mode), 0);
        scan(0, 5'd0, 0, q);
        chk("R1 dbg_ctrl reset read", q, 0);

        // R2/R8/R9: write sweep, mailbox addresses excluded
        for (int a = 0; a < 32; a++)
            if (a != 4 && a != 5) scan(1, 5'(a), pat(a), q);
        chk("R7 monitor follows bit4", 32'(monitor_mode), 32'(pat(0)[4]));

        // R2: pipelined read sweep, each result belongs to the previous address
        scan(0, 5'd0, 0, q);
        prev = 0;
        for (int a = 1; a < 32; a++) begin
            if (a != 5) begin
                scan(0, 5'(a), 0, q);
                chk({"R2 ", tag(prev)}, q, exp_val(prev));
                prev = a;
            end
        end
        scan(0, 5'd4, 0, q);
        chk("R9 addr31 read", q, 0);
        chk("R3 capture upper bits", 32'(last_hi), 0);

        // R7: control width mask and monitor bit
        scan(1, 5'd0, 32'hFFFF_FFFF, q);
        chk("R7 monitor set", 32'(monitor_mode), 1);
        scan(0, 5'd0, 0, q);
        scan(0, 5'd4, 0, q);
        chk("R7 masked readback", q, 32'h3F);
        scan(1, 5'd0, 32'h0, q);
        chk("R7 monitor clear", 32'(monitor_mode), 0);

        // R4: host-to-core mailbox
        scan(1, 5'd5, 32'hCAFE_0001, q);
        chk("R4 rx_full set", 32'(core_rx_full), 1);
        chk("R4 rx_data", core_rx_data, 32'hCAFE_0001);
        scan(0, 5'd4, 0, q);
        scan(0, 5'd4, 0, q);
        chk("R6 status R bit", q, 32'h2000_0001);
        @(negedge clk) core_rx_take = 1;
        @(negedge clk) core_rx_take = 0;
        chk("R4 rx_full cleared", 32'(core_rx_full), 0);
        // R6: status write ignored
        scan(1, 5'd4, 32'hFFFF_FFFF, q);
        scan(0, 5'd4, 0, q);
        chk("R6 status after write", q, 32'h2000_0000);

        // R5: core-to-host words popped by successive data reads
        put(32'h1111_AAAA);
        scan(0, 5'd5, 0, q);
        chk("R6 status W bit", q, 32'h2000_0002);
        scan(0, 5'd5, 0, q);
        chk("R5 first word", q, 32'h1111_AAAA);
        chk("R5 popped", 32'(core_tx_full), 0);
        put(32'h2222_BBBB);
        scan(0, 5'd4, 0, q);
        chk("R5 second word", q, 32'h2222_BBBB);
        chk("R5 popped again", 32'(core_tx_full), 0);
        scan(0, 5'd4, 0, q);
        chk("R5 status empty", q, 32'h2000_0000);

        // R6: status read leaves a pending word in place
        put(32'h3333_CCCC);
        scan(0, 5'd4, 0, q);
        chk("R6 status read W", q, 32'h2000_0002);
        chk("R6 tx_full kept", 32'(core_tx_full), 1);
        scan(0, 5'd5, 0, q);
        scan(0, 5'd4, 0, q);
        chk("R5 third word", q, 32'h3333_CCCC);
        chk("R5 drained", 32'(core_tx_full), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule